// File: doc/BRIEF.md
# Bus Controller Message Timing Unit

This block supplies the timing events that a serial avionics bus controller needs between and during messages. It runs from the controller's system clock, which may be 10, 12, 16 or 20 MHz as chosen by a two-bit select. Each timer has its own prescaler. The prescaler restarts when its timer starts, so every window is an exact number of clock cycles after the request.

Three timers share the divided time base. The intermessage gap timer counts a programmed number of microseconds and then adds a stretch in clock cycles. The stretch covers enhanced controller mode and host accesses that collide with the controller's own start-of-message and end-of-message transfer sequences. The response timer signals a missing status reply after one of four selectable limits. The transmitter watchdog flags a transmission that runs on for too long. Every result is a one-cycle pulse.

The reset input is asynchronous and active low. The block releases it internally through two flops, so it takes effect two clock edges after `rst_n` rises.

Top module: `bc_msg_timer`

## Requirements
- R1: `clk_sel` selects the half-microsecond prescale: code 0 = 5 cycles (10 MHz), 1 = 6 (12 MHz), 2 = 8 (16 MHz), 3 = 10 (20 MHz). A plain gap of N µs ends N*2*prescale cycles after the `gap_start` edge.
- R2: A nonzero `gap_us` sets the gap in 1 µs steps, with 16 bits (up to 65,535 µs). `gap_us` = 0 selects the default minimum gap of 10 µs.
- R3: When `enh_mode` is 1, the gap is 10 clock cycles longer.
- R4: A collision is a cycle in which `host_access`, `xfer_seq_active` and `enh_access_en` are all 1. Each collision counted since the previous gap's stretch began adds 6 cycles to the gap. With `enh_access_en` = 0, no cycle counts.
- R5: The collision count saturates at 12, capping the stretch at 72 cycles. All stretch cycles come after the programmed microsecond part.
- R6: A `gap_start` that arrives while a gap is running is ignored, and the running gap ends at its original time.
- R7: `resp_arm` starts the response timer. `response_timeout` pulses after 37, 45, 101 or 256 half-microseconds (18.5, 22.5, 50.5 or 128 µs) for `tmo_sel` codes 0, 1, 2 and 3.
- R8: `resp_seen` cancels a running response timer, and it wins over an expiry in the same cycle. `resp_arm` is ignored while the timer runs.
- R9: `tx_watchdog_trip` pulses once after 1321 half-microseconds (660.5 µs) of continuous `tx_active`. Dropping `tx_active` restarts the count from zero.
- R10: `gap_done`, `response_timeout` and `tx_watchdog_trip` are one-cycle pulses. All three are 0 during reset and right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | System clock rate code |
| enh_mode | input | 1 | Enhanced controller mode, adds 10 cycles to the gap |
| enh_access_en | input | 1 | Enables stretching on host collisions |
| gap_us | input | 16 | Gap length in µs, 0 selects the default |
| gap_start | input | 1 | Starts the intermessage gap |
| host_access | input | 1 | A host access is taking place this cycle |
| xfer_seq_active | input | 1 | A start- or end-of-message transfer sequence is in progress |
| tmo_sel | input | 2 | Response timeout code |
| resp_arm | input | 1 | Command mid-parity reached, starts the response timer |
| resp_seen | input | 1 | Status mid-sync reached, cancels the response timer |
| tx_active | input | 1 | The transmitter is driving the bus |
| gap_done | output | 1 | Pulse: gap elapsed, next message may start |
| response_timeout | output | 1 | Pulse: no response within the limit |
| tx_watchdog_trip | output | 1 | Pulse: transmission too long |

## Verification
The gap is timed under four groups of inputs:
- Plain gaps at each clock code show whether the prescale is correct per rate.
- A zero length shows whether the default is substituted.
- Enhanced mode shows whether its 10 cycles are added.
- Collision bursts are tried with the enable on and off, and with pulses on only one of the two qualifying inputs. These show whether exactly the qualified cycles count and whether the cap of 12 holds.

Randomized mixes of rate, length, mode and burst size check that the terms add up. Restart, cancel and watchdog cases show that a second request inside a window leaves its end time unchanged, and that a drop of transmit restarts the watchdog count.

// File: rtl/bcmt_pkg.sv
package bcmt_pkg;

  localparam int DIV_W = 4;

  typedef enum logic [1:0] {
    GAP_IDLE    = 2'd0,
    GAP_USEC    = 2'd1,
    GAP_STRETCH = 2'd2
  } gap_state_t;

  // Cycles per half microsecond for each clock rate code
  function automatic logic [DIV_W-1:0] half_us_div(input logic [1:0] sel);
    case (sel)
      2'd0:    half_us_div = 4'd5;
      2'd1:    half_us_div = 4'd6;
      2'd2:    half_us_div = 4'd8;
      default: half_us_div = 4'd10;
    endcase
  endfunction

  // Response limit in half microseconds
  function automatic logic [8:0] tmo_halves(input logic [1:0] sel);
    case (sel)
      2'd0:    tmo_halves = 9'd37;
      2'd1:    tmo_halves = 9'd45;
      2'd2:    tmo_halves = 9'd101;
      default: tmo_halves = 9'd256;
    endcase
  endfunction

endpackage

// File: rtl/bcmt_prescaler.sv
module bcmt_prescaler
  import bcmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == div - 1'b1);
    cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bcmt_halfus_timer.sv
module bcmt_halfus_timer
  import bcmt_pkg::*;
#(
  parameter int LIM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic             clear,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);
  logic             busy_q, busy_d, exp_d, tick;
  logic [LIM_W-1:0] h_q, h_d, lim_q, lim_d;

  bcmt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .en(busy_q), .div(div), .tick(tick)
  );

  always_comb begin
    busy_d = busy_q;
    h_d    = h_q;
    lim_d  = lim_q;
    exp_d  = 1'b0;
    if (clear) begin
      busy_d = 1'b0;
      h_d    = '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        h_d    = '0;
        lim_d  = limit;
      end
    end else if (tick) begin
      if (h_q + 1'b1 == lim_q) begin
        exp_d  = 1'b1;
        busy_d = 1'b0;
        h_d    = '0;
      end else begin
        h_d = h_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      h_q    <= '0;
      lim_q  <= '0;
      expire <= 1'b0;
    end else begin
      busy_q <= busy_d;
      h_q    <= h_d;
      lim_q  <= lim_d;
      expire <= exp_d;
    end
  end
endmodule

// File: rtl/bcmt_gap_ctrl.sv
module bcmt_gap_ctrl
  import bcmt_pkg::*;
#(
  parameter int GAP_W         = 16,
  parameter int DEF_GAP_US    = 10,
  parameter int ENH_EXTRA_CYC = 10,
  parameter int COLL_CYC      = 6,
  parameter int COLL_MAX      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic [GAP_W-1:0] gap_us,
  input  logic             start,
  input  logic             enh_mode,
  input  logic             coll_evt,
  output logic             done
);
  localparam int HW = GAP_W + 1;
  localparam int CW = $clog2(COLL_MAX + 1);
  localparam int XW = $clog2(ENH_EXTRA_CYC + COLL_CYC * COLL_MAX + 1);

  gap_state_t    st_q, st_d;
  logic [HW-1:0] h_q, h_d, lim_q, lim_d, gap_eff;
  logic [XW-1:0] xc_q, xc_d, extra;
  logic [CW-1:0] coll_q, coll_d;
  logic          done_d, tick;

  bcmt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .en(st_q == GAP_USEC), .div(div), .tick(tick)
  );

  always_comb begin
    gap_eff = (gap_us == '0) ? HW'(DEF_GAP_US) : {1'b0, gap_us};
    extra   = (enh_mode ? XW'(ENH_EXTRA_CYC) : '0) + XW'(COLL_CYC * int'(coll_q));
    st_d    = st_q;
    h_d     = h_q;
    lim_d   = lim_q;
    xc_d    = xc_q;
    done_d  = 1'b0;
    coll_d  = (coll_evt && coll_q < CW'(COLL_MAX)) ? coll_q + 1'b1 : coll_q;
    case (st_q)
      GAP_IDLE: if (start) begin
        st_d  = GAP_USEC;
        h_d   = '0;
        lim_d = gap_eff << 1;
      end
      GAP_USEC: if (tick) begin
        if (h_q + 1'b1 == lim_q) begin
          h_d    = '0;
          coll_d = coll_evt ? CW'(1) : '0;  // snapshot taken, restart count
          if (extra == '0) begin
            done_d = 1'b1;
            st_d   = GAP_IDLE;
          end else begin
            xc_d = extra;
            st_d = GAP_STRETCH;
          end
        end else begin
          h_d = h_q + 1'b1;
        end
      end
      GAP_STRETCH: begin
        if (xc_q == XW'(1)) begin
          done_d = 1'b1;
          st_d   = GAP_IDLE;
        end
        xc_d = xc_q - 1'b1;
      end
      default: st_d = GAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GAP_IDLE;
      h_q    <= '0;
      lim_q  <= '0;
      xc_q   <= '0;
      coll_q <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      h_q    <= h_d;
      lim_q  <= lim_d;
      xc_q   <= xc_d;
      coll_q <= coll_d;
      done   <= done_d;
    end
  end
endmodule

// File: rtl/bc_msg_timer.sv
module bc_msg_timer
  import bcmt_pkg::*;
#(
  parameter int GAP_W         = 16,
  parameter int DEF_GAP_US    = 10,
  parameter int ENH_EXTRA_CYC = 10,
  parameter int COLL_CYC      = 6,
  parameter int COLL_MAX      = 12,
  parameter int WD_HALVES     = 1321
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  input  logic             enh_mode,
  input  logic             enh_access_en,
  input  logic [GAP_W-1:0] gap_us,
  input  logic             gap_start,
  input  logic             host_access,
  input  logic             xfer_seq_active,
  input  logic [1:0]       tmo_sel,
  input  logic             resp_arm,
  input  logic             resp_seen,
  input  logic             tx_active,
  output logic             gap_done,
  output logic             response_timeout,
  output logic             tx_watchdog_trip
);
  localparam int WD_W  = $clog2(WD_HALVES + 1);
  localparam int TMO_W = 9;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n, tx_prev_q;
  logic [DIV_W-1:0] div;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign div       = half_us_div(clk_sel);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) tx_prev_q <= 1'b0;
    else            tx_prev_q <= tx_active;
  end

  bcmt_gap_ctrl #(
    .GAP_W(GAP_W), .DEF_GAP_US(DEF_GAP_US), .ENH_EXTRA_CYC(ENH_EXTRA_CYC),
    .COLL_CYC(COLL_CYC), .COLL_MAX(COLL_MAX)
  ) u_gap (
    .clk(clk), .rst_n(rst_int_n), .div(div), .gap_us(gap_us),
    .start(gap_start), .enh_mode(enh_mode),
    .coll_evt(host_access & xfer_seq_active & enh_access_en),
    .done(gap_done)
  );

  bcmt_halfus_timer #(.LIM_W(TMO_W)) u_resp (
    .clk(clk), .rst_n(rst_int_n), .div(div), .start(resp_arm),
    .clear(resp_seen), .limit(tmo_halves(tmo_sel)), .expire(response_timeout)
  );

  bcmt_halfus_timer #(.LIM_W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_int_n), .div(div), .start(tx_active & ~tx_prev_q),
    .clear(~tx_active), .limit(WD_W'(WD_HALVES)), .expire(tx_watchdog_trip)
  );
endmodule

// File: rtl/bcmt_checker.sv
module bcmt_checker (
  input logic clk,
  input logic rst_n,
  input logic resp_seen,
  input logic tx_active,
  input logic gap_done,
  input logic response_timeout,
  input logic tx_watchdog_trip
);
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !gap_done && !response_timeout && !tx_watchdog_trip);

  a_r10_gap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done |=> !gap_done);

  a_r10_tmo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    response_timeout |=> !response_timeout);

  a_r10_wd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_watchdog_trip |=> !tx_watchdog_trip);

  a_r8_seen_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    response_timeout |-> !$past(resp_seen));

  a_r9_trip_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_watchdog_trip |-> $past(tx_active));
endmodule

bind bc_msg_timer bcmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .resp_seen(resp_seen), .tx_active(tx_active),
  .gap_done(gap_done), .response_timeout(response_timeout),
  .tx_watchdog_trip(tx_watchdog_trip)
);

// File: tb/tb_bc_msg_timer.sv
module tb_bc_msg_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  clk_sel = '0, tmo_sel = '0;
  logic        enh_mode = 0, enh_access_en = 0, gap_start = 0;
  logic        host_access = 0, xfer_seq_active = 0;
  logic        resp_arm = 0, resp_seen = 0, tx_active = 0;
  logic [15:0] gap_us = '0;
  logic        gap_done, response_timeout, tx_watchdog_trip;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bc_msg_timer dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .enh_mode(enh_mode),
    .enh_access_en(enh_access_en), .gap_us(gap_us), .gap_start(gap_start),
    .host_access(host_access), .xfer_seq_active(xfer_seq_active),
    .tmo_sel(tmo_sel), .resp_arm(resp_arm), .resp_seen(resp_seen),
    .tx_active(tx_active), .gap_done(gap_done),
    .response_timeout(response_timeout), .tx_watchdog_trip(tx_watchdog_trip)
  );

  function automatic int div_of(input int sel);
    case (sel) 0: return 5; 1: return 6; 2: return 8; default: return 10; endcase
  endfunction

  function automatic int tmo_of(input int sel);
    case (sel) 0: return 37; 1: return 45; 2: return 101; default: return 256; endcase
  endfunction

  function automatic int gap_exp(input int sel, input int us, input bit enh,
                                 input bit acc, input int ncoll);
    int u = (us == 0) ? 10 : us;
    int c = acc ? ((ncoll > 12) ? 12 : ncoll) : 0;
    return 2 * u * div_of(sel) + (enh ? 10 : 0) + 6 * c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit sig(input int which);
    case (which)
      0: return gap_done;
      1: return response_timeout;
      default: return tx_watchdog_trip;
    endcase
  endfunction

  // Counts cycles after the start edge until the pulse; -1 if none by maxc.
  // kind: 0 none, 1 gap_start, 2 resp_arm, 3 resp_seen, 4 tx_active drop
  task automatic await(input int which, input int maxc, input int kick_at,
                       input int kind, output int n);
    n = 0;
    forever begin
      @(posedge clk); @(negedge clk);
      n++;
      gap_start = 0; resp_arm = 0; resp_seen = 0;
      if (kind == 4 && n == kick_at + 1) tx_active = 1;
      if (sig(which)) break;
      if (n >= maxc) begin n = -1; break; end
      if (n == kick_at) begin
        case (kind)
          1: gap_start = 1;
          2: resp_arm = 1;
          3: resp_seen = 1;
          4: tx_active = 0;
          default: ;
        endcase
      end
    end
  endtask

  task automatic inject(input int ncoll);
    for (int i = 0; i < ncoll; i++) begin
      @(negedge clk); host_access = 1; xfer_seq_active = 1;
      @(negedge clk); host_access = 1; xfer_seq_active = 0;
      @(negedge clk); host_access = 0; xfer_seq_active = 1;
      @(negedge clk); host_access = 0; xfer_seq_active = 0;
    end
  endtask

  task automatic run_gap(input string req, input int sel, input int us,
                         input bit enh, input bit acc, input int ncoll);
    int n, e;
    clk_sel = 2'(sel); gap_us = 16'(us); enh_mode = enh; enh_access_en = acc;
    inject(ncoll);
    @(negedge clk); gap_start = 1;
    @(negedge clk); gap_start = 0;
    e = gap_exp(sel, us, enh, acc, ncoll);
    await(0, e + 200, -5, 0, n);
    check(n == e, req, n, e);
    @(negedge clk);
    check(!gap_done, "R10 gap_done single cycle", int'(gap_done), 0);
  endtask

  initial begin
    int n, e;
    void'($urandom(32'd1553));
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    check(!gap_done && !response_timeout && !tx_watchdog_trip, "R10 reset outputs",
          int'(gap_done) + int'(response_timeout) + int'(tx_watchdog_trip), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!gap_done && !response_timeout && !tx_watchdog_trip, "R10 after reset",
          int'(gap_done) + int'(response_timeout) + int'(tx_watchdog_trip), 0);

    for (int s = 0; s < 4; s++) run_gap("R1 plain gap per rate", s, 3, 0, 0, 0);
    run_gap("R2 default gap for zero", 0, 0, 0, 0, 0);
    run_gap("R2 programmed gap", 1, 17, 0, 0, 0);
    run_gap("R3 enhanced mode extra", 2, 4, 1, 0, 0);
    run_gap("R4 two collisions", 0, 2, 0, 1, 2);
    run_gap("R4 collisions disabled", 0, 2, 0, 0, 5);
    run_gap("R5 collision cap", 3, 1, 1, 1, 15);
    run_gap("R5 exactly twelve", 1, 1, 0, 1, 12);

    // R6: second start during a running gap
    clk_sel = 0; gap_us = 5; enh_mode = 0; enh_access_en = 0;
    @(negedge clk); gap_start = 1;
    @(negedge clk); gap_start = 0;
    await(0, 400, 30, 1, n);
    check(n == 50, "R6 restart ignored", n, 50);
    await(0, 150, -5, 0, n);
    check(n == -1, "R6 no second gap_done", n, -1);

    for (int t = 0; t < 24; t++) begin
      int s = int'($urandom % 4), u = int'($urandom % 30);
      bit en = 1'($urandom), ac = 1'($urandom);
      int c = int'($urandom % 16);
      run_gap("R1 R3 R4 random gap", s, u, en, ac, c);
    end

    // R7: timeout codes
    for (int k = 0; k < 4; k++) begin
      clk_sel = 2'((k + 1) % 4); tmo_sel = 2'(k);
      @(negedge clk); resp_arm = 1;
      @(negedge clk); resp_arm = 0;
      e = tmo_of(k) * div_of((k + 1) % 4);
      await(1, e + 100, -5, 0, n);
      check(n == e, "R7 timeout value", n, e);
    end

    // R8: cancel and re-arm
    clk_sel = 0; tmo_sel = 0;
    @(negedge clk); resp_arm = 1;
    @(negedge clk); resp_arm = 0;
    await(1, 3000, 20, 3, n);
    check(n == -1, "R8 resp_seen cancels", n, -1);
    @(negedge clk); resp_arm = 1;
    @(negedge clk); resp_arm = 0;
    await(1, 400, 30, 2, n);
    check(n == 185, "R8 re-arm ignored", n, 185);

    // R9: watchdog
    clk_sel = 0;
    @(negedge clk); tx_active = 1;
    @(negedge clk);
    await(2, 20000, -5, 0, n);
    check(n == 1321 * 5, "R9 watchdog trip time", n, 1321 * 5);
    await(2, 200, -5, 0, n);
    check(n == -1, "R9 single trip per transmission", n, -1);
    @(negedge clk); tx_active = 0;
    clk_sel = 3;
    @(negedge clk); tx_active = 1;
    @(negedge clk);
    await(2, 30000, 1000, 4, n);
    check(n == 1002 + 13210, "R9 drop restarts watchdog", n, 1002 + 13210);
    @(negedge clk); tx_active = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule